// File: doc/BRIEF.md
# Descriptor Ring Source Engine

This block is the sending half of a copy engine. Software builds a ring of descriptors in memory, each naming a source buffer, a byte count and a set of flags, and then moves a write index forward through a register port. The engine walks the ring from its own read index up to that write index. For each entry it fetches the descriptor, checks the byte count against a programmed limit, reads the buffer word by word and presents the bytes on a ready/valid stream. When a descriptor is finished it moves its read index on, and software can watch that index to learn how much of the ring has been used.

Descriptors carrying the gather flag are joined to the entries that follow, so several buffers leave as one stream transfer with one end marker and one completion pulse. The ring is a power of two in length, indices wrap through a mask of size minus one, and one slot is always kept free so that a full ring can be told apart from an empty one.

The engine is a five-state machine. IDLE waits until the ring is programmed (size not zero) and the read index differs from the write index, then moves to FETCH. FETCH holds a descriptor request until it is acknowledged and moves to CHECK. CHECK either rejects the entry (back to IDLE, error pulse, read index advanced) or loads the buffer pointer and count and moves to READ. READ holds a data request until it is acknowledged and moves to EMIT. EMIT presents one word; once it is accepted the machine goes back to READ if bytes remain, or to IDLE after the final word of the descriptor.

Top module: `src_ring_engine`

## Requirements
- R1: After reset the read index is 0, the ring is reported not full, and no request, stream word, completion pulse or error pulse is active.
- R2: Register offset 0 is the ring base address, 1 the ring size in entries, 2 the write index and 3 the control word (bits 15:0 maximum byte count, bit 16 ring-wide byte swap). A descriptor is 8 bytes at base + 8 × read index: the low 32 bits are the buffer address and the high 32 bits hold the byte count in bits 15:0 and the flags in bits 31:16. The engine fetches while the size is nonzero and the read index differs from the write index, and it holds a request and its address until it is acknowledged.
- R3: Buffer bytes leave as 32-bit little-endian words read from consecutive word addresses starting at the (word-aligned) buffer address. Every word has all four keep bits set except the last word of a descriptor, whose keep bits mark the low lanes that hold the remaining 1 to 4 bytes. A word that is not accepted stays on the output unchanged.
- R4: When flag bit 1 of a descriptor or control bit 16 is set, every output word of that descriptor has its four bytes in reverse order; the keep bits are unchanged.
- R5: Flag bit 0 is the gather flag: the end-of-transfer marker is raised only on the last word of a descriptor whose gather flag is clear. Each word carries the descriptor's transfer ID from flag bits 15:2.
- R6: A completion pulse lasting one cycle appears in the cycle after the word carrying the end marker is accepted, exactly once per transfer, with the transfer ID of the closing descriptor.
- R7: A descriptor whose byte count is zero or greater than the programmed maximum produces a one-cycle error pulse and no stream words, still advances the read index, and does not close an open gathered transfer.
- R8: The read index increases by one, modulo the ring size, when a descriptor is finished or rejected, and never leaves the range 0 to size − 1.
- R9: The ring is reported full when the size is nonzero and (write index − (read index − 1)) AND (size − 1) is zero.
- R10: With size 0 the engine issues no requests. Writing the size register sets both the read index and the write index to 0; written write-index values are masked by size − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| rd_idx | output | IDXW | Current read index |
| ring_full | output | 1 | Ring has no free slot |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | AW | Descriptor byte address |
| desc_ack | input | 1 | Descriptor fetch acknowledge, data valid |
| desc_rdata | input | 64 | Descriptor contents |
| data_req | output | 1 | Buffer word read request |
| data_addr | output | AW | Buffer word byte address |
| data_ack | input | 1 | Buffer read acknowledge, data valid |
| data_rdata | input | DW | Buffer word |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | DW | Stream word |
| out_keep | output | DW/8 | Valid byte lanes |
| out_last | output | 1 | End of transfer |
| out_id | output | 14 | Transfer ID of the current word |
| done_pulse | output | 1 | Transfer complete |
| done_id | output | 14 | Transfer ID of the completed transfer |
| err_pulse | output | 1 | Descriptor rejected |

## Verification
The bench goes after byte counts that are not a multiple of four, where a wrong keep computation would drop or add bytes, and after gathered chains, where a design that ends the transfer on every descriptor would give extra end markers and completion pulses. Rejected entries are placed in the middle of chains: a design that closed the transfer there, or did not advance, would leave beats out of order or stop. Read-index wrap, the full test with fetches held back, ring-wide swap against per-descriptor swap, and resetting the ring through the size register are each aimed at a design that masks or resets its indices wrongly, which would fetch from the wrong slot or stall.

// File: rtl/src_ring_pkg.sv
package src_ring_pkg;
    localparam int DESC_W      = 64;
    localparam int DESC_BYTES  = 8;
    localparam int ID_W        = 14;
    localparam int FLAG_GATHER = 0;
    localparam int FLAG_SWAP   = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_EMIT
    } eng_state_t;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] nbytes;
        logic [31:0] buf_addr;
    } desc_t;
endpackage

// File: rtl/ring_index.sv
module ring_index #(
    parameter int IDXW = 16
) (
    input  logic [IDXW:0]   size,
    input  logic [IDXW-1:0] rd,
    input  logic [IDXW-1:0] wr,
    output logic [IDXW-1:0] mask,
    output logic [IDXW-1:0] next_rd,
    output logic            pending,
    output logic            full
);
    logic [IDXW-1:0] gap;

    always_comb begin
        mask    = (size == '0) ? '0 : IDXW'(size - 1'b1);
        next_rd = (rd + IDXW'(1)) & mask;
        gap     = (wr - (rd - IDXW'(1))) & mask;
        pending = (size != '0) && (rd != wr);
        full    = (size != '0) && (gap == '0);
    end
endmodule

// File: rtl/lane_pack.sv
module lane_pack #(
    parameter int DW   = 32,
    parameter int REMW = 17
) (
    input  logic [DW-1:0]     word_in,
    input  logic              swap,
    input  logic [REMW-1:0]   remaining,
    output logic [DW-1:0]     word_out,
    output logic [DW/8-1:0]   keep,
    output logic              final_word
);
    localparam int WB = DW / 8;

    for (genvar i = 0; i < WB; i++) begin : g_lane
        assign word_out[8*i +: 8] = swap ? word_in[8*(WB-1-i) +: 8] : word_in[8*i +: 8];
        assign keep[i]            = remaining > REMW'(i);
    end

    assign final_word = remaining <= REMW'(WB);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
    parameter int IDXW = 16,
    parameter int AW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [31:0]     wdata,
    input  logic [IDXW-1:0] mask,
    output logic [AW-1:0]   base,
    output logic [IDXW:0]   size,
    output logic [IDXW-1:0] wr_idx,
    output logic [15:0]     max_len,
    output logic            swap_all,
    output logic            size_wr
);
    assign size_wr = we && (addr == 2'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base     <= '0;
            size     <= '0;
            wr_idx   <= '0;
            max_len  <= 16'hFFFF;
            swap_all <= 1'b0;
        end else if (we) begin
            unique case (addr)
                2'd0: base <= AW'(wdata);
                2'd1: begin
                    size   <= (IDXW+1)'(wdata);
                    wr_idx <= '0;
                end
                2'd2: wr_idx <= IDXW'(wdata) & mask;
                default: begin
                    max_len  <= wdata[15:0];
                    swap_all <= wdata[16];
                end
            endcase
        end
    end
endmodule

// File: rtl/src_ring_engine.sv
module src_ring_engine
    import src_ring_pkg::*;
#(
    parameter int IDXW = 16,
    parameter int AW   = 32,
    parameter int DW   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [1:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [IDXW-1:0]       rd_idx,
    output logic                  ring_full,
    output logic                  desc_req,
    output logic [AW-1:0]         desc_addr,
    input  logic                  desc_ack,
    input  logic [DESC_W-1:0]     desc_rdata,
    output logic                  data_req,
    output logic [AW-1:0]         data_addr,
    input  logic                  data_ack,
    input  logic [DW-1:0]         data_rdata,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DW-1:0]         out_data,
    output logic [DW/8-1:0]       out_keep,
    output logic                  out_last,
    output logic [ID_W-1:0]       out_id,
    output logic                  done_pulse,
    output logic [ID_W-1:0]       done_id,
    output logic                  err_pulse
);
    localparam int WB   = DW / 8;
    localparam int REMW = 17;

    eng_state_t      st, st_nx;
    desc_t           desc_q;
    logic [AW-1:0]   ring_base;
    logic [IDXW:0]   ring_size;
    logic [IDXW-1:0] wr_idx, ring_mask, next_rd;
    logic [15:0]     max_len;
    logic            swap_all, size_wr, pending;
    logic [REMW-1:0] remain;
    logic [AW-1:0]   ptr;
    logic [DW-1:0]   swapped;
    logic            final_word, bad_desc, gather, swap_eff;

    cfg_regs #(.IDXW(IDXW), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .mask(ring_mask), .base(ring_base), .size(ring_size), .wr_idx(wr_idx),
        .max_len(max_len), .swap_all(swap_all), .size_wr(size_wr)
    );

    ring_index #(.IDXW(IDXW)) u_idx (
        .size(ring_size), .rd(rd_idx), .wr(wr_idx), .mask(ring_mask),
        .next_rd(next_rd), .pending(pending), .full(ring_full)
    );

    lane_pack #(.DW(DW), .REMW(REMW)) u_lane (
        .word_in(data_rdata), .swap(swap_eff), .remaining(remain),
        .word_out(swapped), .keep(out_keep), .final_word(final_word)
    );

    assign gather   = desc_q.flags[FLAG_GATHER];
    assign swap_eff = desc_q.flags[FLAG_SWAP] | swap_all;
    assign bad_desc = (desc_q.nbytes == 16'd0) || (desc_q.nbytes > max_len);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (pending) st_nx = ST_FETCH;
            ST_FETCH: if (desc_ack) st_nx = ST_CHECK;
            ST_CHECK: st_nx = bad_desc ? ST_IDLE : ST_READ;
            ST_READ:  if (data_ack) st_nx = ST_EMIT;
            ST_EMIT:  if (out_ready) st_nx = final_word ? ST_IDLE : ST_READ;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q     <= '0;
            remain     <= '0;
            ptr        <= '0;
            rd_idx     <= '0;
            out_data   <= '0;
            done_pulse <= 1'b0;
            done_id    <= '0;
            err_pulse  <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
            unique case (st)
                ST_FETCH: if (desc_ack) desc_q <= desc_t'(desc_rdata);
                ST_CHECK: begin
                    if (bad_desc) begin
                        err_pulse <= 1'b1;
                        rd_idx    <= next_rd;
                    end else begin
                        remain <= REMW'(desc_q.nbytes);
                        ptr    <= AW'(desc_q.buf_addr);
                    end
                end
                ST_READ: if (data_ack) out_data <= swapped;
                ST_EMIT: begin
                    if (out_ready) begin
                        if (final_word) begin
                            rd_idx <= next_rd;
                            if (!gather) begin
                                done_pulse <= 1'b1;
                                done_id    <= desc_q.flags[15:2];
                            end
                        end else begin
                            remain <= remain - REMW'(WB);
                            ptr    <= ptr + AW'(WB);
                        end
                    end
                end
                default: ;
            endcase
            if (size_wr) rd_idx <= '0;
        end
    end

    assign desc_req  = (st == ST_FETCH);
    assign desc_addr = ring_base + (AW'(rd_idx) << 3);
    assign data_req  = (st == ST_READ);
    assign data_addr = ptr;
    assign out_valid = (st == ST_EMIT);
    assign out_last  = final_word && !gather;
    assign out_id    = desc_q.flags[15:2];
endmodule

// File: rtl/src_ring_engine_chk.sv
module src_ring_engine_chk #(
    parameter int IDXW = 16,
    parameter int AW   = 32,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic [1:0]      reg_addr,
    input logic [IDXW-1:0] rd_idx,
    input logic [IDXW-1:0] mask,
    input logic            desc_req,
    input logic            desc_ack,
    input logic [AW-1:0]   desc_addr,
    input logic            out_valid,
    input logic            out_ready,
    input logic [DW-1:0]   out_data,
    input logic            out_last,
    input logic            done_pulse,
    input logic            err_pulse
);
    assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req && !desc_ack |=> desc_req && $stable(desc_addr));

    assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_done_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(out_valid && out_ready && out_last));

    assert_reject_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !out_valid && !done_pulse);

    assert_idx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != $past(rd_idx)) && !$past(reg_we && reg_addr == 2'd1)
        |-> rd_idx == (($past(rd_idx) + IDXW'(1)) & $past(mask)));

    assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx & ~mask) == '0);
endmodule

bind src_ring_engine src_ring_engine_chk #(.IDXW(IDXW), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .rd_idx(rd_idx), .mask(ring_mask), .desc_req(desc_req), .desc_ack(desc_ack),
    .desc_addr(desc_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .done_pulse(done_pulse),
    .err_pulse(err_pulse)
);

// File: tb/src_ring_engine_test.sv
module src_ring_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDXW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [IDXW-1:0] rd_idx;
    logic ring_full, desc_req, desc_ack, data_req, data_ack;
    logic [31:0] desc_addr, data_addr, data_rdata, out_data;
    logic [63:0] desc_rdata;
    logic out_valid, out_ready, out_last, done_pulse, err_pulse;
    logic [3:0] out_keep;
    logic [13:0] out_id, done_id;

    logic [31:0] mem [0:1023];
    logic mem_rdy = 1'b0;
    logic hold_desc = 1'b0;

    int checks = 0, errors = 0, cycles = 0;
    int got_err = 0, exp_err = 0, saw_req = 0;
    int sw_wr = 0, ring_sz = 0, cur_max = 16'hFFFF;
    int ring_base = 0;
    bit cur_swap = 0;

    logic [31:0] q_data[$];
    logic [3:0]  q_keep[$];
    bit          q_last[$];
    logic [13:0] q_id[$];
    logic [13:0] q_done[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign desc_ack   = desc_req && mem_rdy && !hold_desc;
    assign data_ack   = data_req && mem_rdy;
    assign desc_rdata = {mem[desc_addr[11:2] + 10'd1], mem[desc_addr[11:2]]};
    assign data_rdata = mem[data_addr[11:2]];

    src_ring_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_idx(rd_idx), .ring_full(ring_full), .desc_req(desc_req), .desc_addr(desc_addr),
        .desc_ack(desc_ack), .desc_rdata(desc_rdata), .data_req(data_req), .data_addr(data_addr),
        .data_ack(data_ack), .data_rdata(data_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_keep(out_keep), .out_last(out_last), .out_id(out_id),
        .done_pulse(done_pulse), .done_id(done_id), .err_pulse(err_pulse)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // stream monitor and random memory / sink readiness
    always @(negedge clk) begin
        bit rdy;
        mem_rdy = ($urandom % 4) != 0;
        rdy = ($urandom % 3) != 0;
        out_ready = rdy;
        if (rst_n) begin
            if (desc_req) saw_req++;
            if (err_pulse) got_err++;
            if (out_valid && rdy) begin
                if (q_data.size() == 0) begin
                    check(0, "R3 unexpected stream word", {32'd0, out_data}, 64'd0);
                end else begin
                    logic [31:0] ed; logic [3:0] ek; bit el; logic [13:0] ei;
                    ed = q_data.pop_front(); ek = q_keep.pop_front();
                    el = q_last.pop_front(); ei = q_id.pop_front();
                    check(out_data == ed, "R3/R4 word data", {32'd0, out_data}, {32'd0, ed});
                    check(out_keep == ek && out_last == el && out_id == ei, "R3/R5 keep,last,id",
                          {out_keep, 3'd0, out_last, 2'd0, out_id}, {ek, 3'd0, el, 2'd0, ei});
                end
            end
            if (done_pulse) begin
                if (q_done.size() == 0) check(0, "R6 unexpected completion", {50'd0, done_id}, 64'd0);
                else begin
                    logic [13:0] e;
                    e = q_done.pop_front();
                    check(done_id == e, "R6 completion id", {50'd0, done_id}, {50'd0, e});
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // place a descriptor at the software write slot and model its effect
    task automatic put_desc(input int addr, input int n, input bit gth, input bit swp, input logic [13:0] id);
        int w;
        w = (ring_base >> 2) + 2 * sw_wr;
        mem[w]     = addr;
        mem[w + 1] = {id, swp, gth, n[15:0]};
        sw_wr = (sw_wr + 1) % ring_sz;
        if (n == 0 || n > cur_max) begin
            exp_err++;
        end else begin
            for (int k = 0; k * 4 < n; k++) begin
                logic [31:0] wd; int rem;
                wd = mem[(addr >> 2) + k];
                if (swp || cur_swap) wd = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]};
                rem = n - 4 * k;
                q_data.push_back(wd);
                q_keep.push_back(rem >= 4 ? 4'hF : 4'((1 << rem) - 1));
                q_last.push_back(rem <= 4 && !gth);
                q_id.push_back(id);
            end
            if (!gth) q_done.push_back(id);
        end
    endtask

    task automatic kick_and_drain(input string tag);
        int t;
        wr_reg(2'd2, sw_wr);
        t = 0;
        while (!(rd_idx == IDXW'(sw_wr) && q_data.size() == 0 && !desc_req) && t < 3000) begin
            @(negedge clk); t++;
        end
        repeat (4) @(negedge clk);
        check(t < 3000 && rd_idx == IDXW'(sw_wr), {tag, " R8 read index after drain"}, 64'(rd_idx), 64'(sw_wr));
        check(q_done.size() == 0, {tag, " R6 completions outstanding"}, 64'(q_done.size()), 64'd0);
        check(got_err == exp_err, {tag, " R7 error pulses"}, 64'(got_err), 64'(exp_err));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_idx == 0 && !ring_full && !desc_req && !data_req && !out_valid && !done_pulse && !err_pulse,
              "R1 reset state", {rd_idx, 7'd0, ring_full, desc_req, data_req, out_valid, done_pulse, err_pulse}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_idx == 0 && !out_valid, "R1 after reset release", 64'(rd_idx), 64'd0);

        // R10: unprogrammed ring stays quiet even with a write index poked
        ring_base = 32'h100;
        wr_reg(2'd0, ring_base);
        wr_reg(2'd2, 32'd3);
        saw_req = 0;
        repeat (10) @(negedge clk);
        check(saw_req == 0 && !ring_full, "R10 size zero issues no request", 64'(saw_req), 64'd0);

        ring_sz = 4;
        wr_reg(2'd1, ring_sz);
        wr_reg(2'd3, 32'h0000FFFF);

        // R2/R3 single descriptor, five bytes: two words, keep F then 1
        put_desc(32'h800, 5, 0, 0, 14'd5);
        kick_and_drain("single");

        // R4 per-descriptor swap
        put_desc(32'h840, 8, 0, 1, 14'd9);
        kick_and_drain("swap");

        // R5/R6 gathered chain of three: one end marker, one completion (wraps ring)
        put_desc(32'h880, 3, 1, 0, 14'd1);
        put_desc(32'h8C0, 6, 1, 0, 14'd2);
        put_desc(32'h900, 4, 0, 0, 14'd3);
        kick_and_drain("gather");

        // R7 oversize and zero length inside a gathered chain
        cur_max = 10;
        wr_reg(2'd3, cur_max);
        put_desc(32'h940, 7, 1, 0, 14'd20);
        put_desc(32'h980, 12, 0, 0, 14'd21);
        put_desc(32'h9C0, 0, 0, 0, 14'd22);
        kick_and_drain("reject");
        put_desc(32'hA00, 9, 0, 0, 14'd23);
        kick_and_drain("reject-close");

        // R9 full ring with fetches held back
        hold_desc = 1'b1;
        begin
            int r0;
            r0 = rd_idx;
            put_desc(32'hA40, 4, 0, 0, 14'd30);
            put_desc(32'hA80, 4, 0, 0, 14'd31);
            wr_reg(2'd2, sw_wr);
            check(!ring_full, "R9 two pending of four not full", 64'(ring_full), 64'd0);
            put_desc(32'hAC0, 4, 0, 0, 14'd32);
            wr_reg(2'd2, sw_wr);
            check(ring_full, "R9 three pending of four is full", 64'(ring_full), 64'd1);
            check(rd_idx == IDXW'(r0), "R2 held fetch keeps index", 64'(rd_idx), 64'(r0));
        end
        hold_desc = 1'b0;
        kick_and_drain("full");

        // R4 ring-wide swap enable
        cur_swap = 1;
        wr_reg(2'd3, 32'h0001_0000 | cur_max);
        put_desc(32'hB00, 6, 0, 0, 14'd40);
        kick_and_drain("ringswap");

        // R10 size write resets both indices
        ring_sz = 8;
        ring_base = 32'h200;
        wr_reg(2'd0, ring_base);
        wr_reg(2'd1, ring_sz);
        sw_wr = 0;
        check(rd_idx == 0 && !ring_full, "R10 size write clears read index", 64'(rd_idx), 64'd0);

        // random batches
        cur_max = 16;
        for (int b = 0; b < 60; b++) begin
            int nd;
            cur_swap = $urandom % 2;
            wr_reg(2'd3, {15'd0, cur_swap, 16'(cur_max)});
            nd = 1 + $urandom % 7;
            for (int d = 0; d < nd; d++) begin
                int n; bit g;
                n = $urandom % 21;
                g = $urandom % 2;
                if (d == nd - 1) begin
                    g = 0;
                    n = 1 + $urandom % 16;
                end
                put_desc(32'h800 + 64 * ($urandom % 30), n, g, $urandom % 2, 14'($urandom));
            end
            kick_and_drain("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule